// File: doc/BRIEF.md
# Standby Domain Rail Sequencer

This block is a timed controller for the standby power domain of a chipset. After reset it lets the real-time-clock well settle. It then switches on the primary rail, the 5 V rail, the suspend acknowledge, the deep-sleep power-good, the resume reset release and the sleep-signal handover. Each step comes after a fixed wait. When the primary domain is no longer needed, the block takes these signals down in its own order, which is not the reverse of power-up. It then parks in a deep-sleep-off state until a new request arrives.

Two active-low request inputs decide whether the primary domain must stay up. Each wait is a cycle count derived from a nanosecond figure and the `CLK_HZ` parameter. While the domain is fully up, a platform power-good input is passed on to the chipset power-good output, and then to the system power-good output. A two-bit status output shows the current phase.

Top module: `rail_seq`

## Requirements
- R1: While reset is held, every enable output, both power-good outputs and `resume_rst_n` are 0, and `seq_status` is 0 (off).
- R2: After reset is released, `seq_status` stays 0 until edge T_RTC, where it becomes 1 (deep-sleep-off). T_RTC is the 9 ms settle time in cycles. Power-up then starts on the next edge with no request needed.
- R3: Power-up raises `prim_rail_en` and sets `seq_status` to 3 (sequencing). Exactly T_PRIM edges later (200 us), `rail5_en` and `susp_ack` rise together.
- R4: T_RAIL edges (10 ms) after the 5 V step, `dsleep_pgood` and `resume_rst_n` rise together.
- R5: T_RSM edges (95 ms) after the reset release, `handover_en` rises and `seq_status` becomes 2 (S5).
- R6: Each wait in cycles is ceil(CLK_HZ x time), with a minimum of one cycle. At 100 kHz, the 400 ns gaps therefore take one cycle each.
- R7: The primary domain is requested when `suspend_warn_n` is 0 or `sleep_s3_n` is 0. A request change is seen on the third edge after it (two synchronizer stages). In S5 with no request, that edge clears both power-good outputs, `handover_en`, `resume_rst_n` and `rail5_en`, and sets status 3. `susp_ack` is left unchanged.
- R8: One 400 ns gap later, `prim_rail_en` and `dsleep_pgood` clear. After one more 400 ns gap, the status returns to 1.
- R9: In deep-sleep-off the block stays idle with no request. A request starts power-up with the same steps as R3 to R5.
- R10: A request change during a running sequence does not alter it. The sequence completes, and the request is evaluated in the state reached.
- R11: In S5 with a request held, `chip_pgood` follows `all_pgood` one edge later, and `sys_pgood` rises one edge after `chip_pgood`. When `all_pgood` falls, both clear on the same edge. Neither is ever 1 outside S5.
- R12: Ordering always holds: `rail5_en` implies `prim_rail_en`, `resume_rst_n` implies `dsleep_pgood`, and `handover_en` implies `resume_rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| suspend_warn_n | input | 1 | Active-low suspend warning; low requests the primary domain |
| sleep_s3_n | input | 1 | Active-low S3 sleep indication; low requests the primary domain |
| all_pgood | input | 1 | Platform rails good, passed on in S5 |
| prim_rail_en | output | 1 | Primary rail enable |
| rail5_en | output | 1 | 5 V rail enable |
| susp_ack | output | 1 | Suspend acknowledge |
| dsleep_pgood | output | 1 | Deep-sleep well power-good |
| resume_rst_n | output | 1 | Active-low resume reset to the chipset |
| handover_en | output | 1 | Lets the chipset drive its sleep signals |
| chip_pgood | output | 1 | Chipset power-good |
| sys_pgood | output | 1 | System power-good |
| seq_status | output | 2 | 0 off, 1 deep-sleep-off, 2 S5, 3 sequencing |

## Verification
The bench builds the block with `CLK_HZ` = 100 000 and two synchronizer stages. At that clock, the millisecond waits become 900, 20, 1000 and 9500 cycles, so complete power-up and power-down runs fit in a short simulation. The 400 ns gaps fall below one period and round up to a single cycle, which tests the rounding floor. Each transition is checked on the cycle before it and on the cycle it occurs, so an off-by-one wait shows up as a mismatch.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

   typedef enum logic [2:0] {
      PH_RTC,
      PH_DSOFF,
      PH_UP_PRIM,
      PH_UP_RAIL,
      PH_UP_RSM,
      PH_S5,
      PH_DN_RAIL,
      PH_DN_TAIL
   } phase_t;

   localparam logic [1:0] ST_OFF   = 2'd0;
   localparam logic [1:0] ST_DSOFF = 2'd1;
   localparam logic [1:0] ST_S5    = 2'd2;
   localparam logic [1:0] ST_SEQ   = 2'd3;

   // ceil(hz * ns / 1e9), never below one cycle
   function automatic longint unsigned ns_to_cycles(longint unsigned hz,
                                                    longint unsigned ns);
      longint unsigned c;
      c = (hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
      if (c == 0) c = 1;
      return c;
   endfunction

   function automatic logic [1:0] status_of(phase_t p);
      case (p)
         PH_RTC:   return ST_OFF;
         PH_DSOFF: return ST_DSOFF;
         PH_S5:    return ST_S5;
         default:  return ST_SEQ;
      endcase
   endfunction

endpackage

// File: rtl/rail_seq_demand.sv
module rail_seq_demand #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic suspend_warn_n,
   input  logic sleep_s3_n,
   output logic need_prim
);
   logic raw_need;
   assign raw_need = !suspend_warn_n || !sleep_s3_n;

   if (STAGES == 0) begin : g_direct
      assign need_prim = raw_need;
   end else begin : g_sync
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain <= '0;
         end else begin
            chain[0] <= raw_need;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
         end
      end
      assign need_prim = chain[STAGES-1];
   end
endmodule

// File: rtl/rail_seq_timer.sv
module rail_seq_timer #(
   parameter int unsigned W           = 8,
   parameter int unsigned RESET_COUNT = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);
   localparam logic [W-1:0] RST_V = W'(RESET_COUNT - 1);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= RST_V;
      else if (load)         cnt <= load_val;
      else if (cnt != '0)    cnt <= cnt - W'(1);
   end

   assign expired = (cnt == '0);

   AST_TIMER_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && expired) |=> expired) else $error("timer left zero"); // R6
   AST_TIMER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt == $past(load_val))) else $error("timer load lost"); // R6
endmodule

// File: rtl/rail_seq_ctrl.sv
module rail_seq_ctrl
   import rail_seq_pkg::*;
#(
   parameter int unsigned W      = 8,
   parameter int unsigned T_PRIM = 1,
   parameter int unsigned T_RAIL = 1,
   parameter int unsigned T_RSM  = 1,
   parameter int unsigned T_OFF  = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         need_prim,
   input  logic         all_pgood,
   input  logic         expired,
   output logic         load,
   output logic [W-1:0] load_val,
   output logic         prim_en,
   output logic         rail5_en,
   output logic         susp_ack,
   output logic         dsleep_pg,
   output logic         resume_n,
   output logic         handover_en,
   output logic         chip_pg,
   output logic         sys_pg,
   output logic [1:0]   status
);
   localparam logic [W-1:0] L_PRIM = W'(T_PRIM - 1);
   localparam logic [W-1:0] L_RAIL = W'(T_RAIL - 1);
   localparam logic [W-1:0] L_RSM  = W'(T_RSM - 1);
   localparam logic [W-1:0] L_OFF  = W'(T_OFF - 1);

   phase_t phase, phase_nx;
   logic   first_up;

   always_comb begin
      phase_nx = phase;
      load     = 1'b0;
      load_val = '0;
      case (phase)
         PH_RTC:     if (expired) phase_nx = PH_DSOFF;
         PH_DSOFF:   if (first_up || need_prim) begin
                        phase_nx = PH_UP_PRIM; load = 1'b1; load_val = L_PRIM;
                     end
         PH_UP_PRIM: if (expired) begin
                        phase_nx = PH_UP_RAIL; load = 1'b1; load_val = L_RAIL;
                     end
         PH_UP_RAIL: if (expired) begin
                        phase_nx = PH_UP_RSM; load = 1'b1; load_val = L_RSM;
                     end
         PH_UP_RSM:  if (expired) phase_nx = PH_S5;
         PH_S5:      if (!need_prim) begin
                        phase_nx = PH_DN_RAIL; load = 1'b1; load_val = L_OFF;
                     end
         PH_DN_RAIL: if (expired) begin
                        phase_nx = PH_DN_TAIL; load = 1'b1; load_val = L_OFF;
                     end
         PH_DN_TAIL: if (expired) phase_nx = PH_DSOFF;
         default:    phase_nx = PH_RTC;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase       <= PH_RTC;
         first_up    <= 1'b1;
         prim_en     <= 1'b0;
         rail5_en    <= 1'b0;
         susp_ack    <= 1'b0;
         dsleep_pg   <= 1'b0;
         resume_n    <= 1'b0;
         handover_en <= 1'b0;
         chip_pg     <= 1'b0;
         sys_pg      <= 1'b0;
         status      <= ST_OFF;
      end else begin
         phase  <= phase_nx;
         status <= status_of(phase_nx);
         if (phase_nx != phase) begin
            case (phase)
               PH_DSOFF: begin
                  prim_en  <= 1'b1;
                  first_up <= 1'b0;
               end
               PH_UP_PRIM: begin
                  rail5_en <= 1'b1;
                  susp_ack <= 1'b1;
               end
               PH_UP_RAIL: begin
                  dsleep_pg <= 1'b1;
                  resume_n  <= 1'b1;
               end
               PH_UP_RSM: handover_en <= 1'b1;
               PH_S5: begin
                  sys_pg      <= 1'b0;
                  chip_pg     <= 1'b0;
                  handover_en <= 1'b0;
                  resume_n    <= 1'b0;
                  rail5_en    <= 1'b0;
               end
               PH_DN_RAIL: begin
                  prim_en   <= 1'b0;
                  dsleep_pg <= 1'b0;
               end
               default: ;
            endcase
         end else if (phase == PH_S5) begin
            chip_pg <= all_pgood;
            sys_pg  <= all_pgood && chip_pg;
         end
      end
   end

   AST_RAIL5_NEEDS_PRIM: assert property (@(posedge clk) disable iff (!rst_n)
      rail5_en |-> prim_en) else $error("5 V without primary"); // R12
   AST_RESUME_NEEDS_DSLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      resume_n |-> dsleep_pg) else $error("reset released early"); // R12
   AST_HANDOVER_NEEDS_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
      handover_en |-> resume_n) else $error("handover in reset"); // R12
   AST_SYS_NEEDS_CHIP: assert property (@(posedge clk) disable iff (!rst_n)
      sys_pg |-> chip_pg) else $error("system good before chipset"); // R11
   AST_PG_ONLY_S5: assert property (@(posedge clk) disable iff (!rst_n)
      chip_pg |-> (status == ST_S5)) else $error("power-good outside S5"); // R11
   AST_RESUME_AFTER_RAIL5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(resume_n) |-> $past(rail5_en)) else $error("reset before 5 V"); // R4
   AST_PRIM_OFF_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(prim_en) |-> (!rail5_en && !resume_n && !handover_en)) else $error("primary cut early"); // R8
endmodule

// File: rtl/rail_seq.sv
module rail_seq #(
   parameter longint unsigned CLK_HZ           = 24_000_000,
   parameter int unsigned     SYNC_STAGES      = 2,
   parameter longint unsigned RTC_SETTLE_NS    = 9_000_000,
   parameter longint unsigned PRIM_TO_RAIL_NS  = 200_000,
   parameter longint unsigned RAIL_TO_RSM_NS   = 10_000_000,
   parameter longint unsigned RSM_TO_HAND_NS   = 95_000_000,
   parameter longint unsigned OFF_GAP_NS       = 400
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       suspend_warn_n,
   input  logic       sleep_s3_n,
   input  logic       all_pgood,
   output logic       prim_rail_en,
   output logic       rail5_en,
   output logic       susp_ack,
   output logic       dsleep_pgood,
   output logic       resume_rst_n,
   output logic       handover_en,
   output logic       chip_pgood,
   output logic       sys_pgood,
   output logic [1:0] seq_status
);
   import rail_seq_pkg::*;

   localparam int unsigned T_RTC  = int'(ns_to_cycles(CLK_HZ, RTC_SETTLE_NS));
   localparam int unsigned T_PRIM = int'(ns_to_cycles(CLK_HZ, PRIM_TO_RAIL_NS));
   localparam int unsigned T_RAIL = int'(ns_to_cycles(CLK_HZ, RAIL_TO_RSM_NS));
   localparam int unsigned T_RSM  = int'(ns_to_cycles(CLK_HZ, RSM_TO_HAND_NS));
   localparam int unsigned T_OFF  = int'(ns_to_cycles(CLK_HZ, OFF_GAP_NS));
   localparam int unsigned M_A    = (T_RTC  > T_PRIM) ? T_RTC  : T_PRIM;
   localparam int unsigned M_B    = (T_RAIL > T_RSM)  ? T_RAIL : T_RSM;
   localparam int unsigned M_C    = (M_A > M_B) ? M_A : M_B;
   localparam int unsigned T_MAX  = (M_C > T_OFF) ? M_C : T_OFF;
   localparam int unsigned CW     = (T_MAX < 2) ? 1 : $clog2(T_MAX);

   if (CLK_HZ < 1) begin : g_bad_hz
      $error("CLK_HZ must be at least 1");
   end
   if (SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES above 4 is not supported");
   end

   logic          need_prim;
   logic          tmr_load;
   logic [CW-1:0] tmr_val;
   logic          tmr_expired;

   rail_seq_demand #(.STAGES(SYNC_STAGES)) u_demand (
      .clk            (clk),
      .rst_n          (rst_n),
      .suspend_warn_n (suspend_warn_n),
      .sleep_s3_n     (sleep_s3_n),
      .need_prim      (need_prim)
   );

   rail_seq_timer #(.W(CW), .RESET_COUNT(T_RTC)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_expired)
   );

   rail_seq_ctrl #(
      .W(CW), .T_PRIM(T_PRIM), .T_RAIL(T_RAIL), .T_RSM(T_RSM), .T_OFF(T_OFF)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .need_prim   (need_prim),
      .all_pgood   (all_pgood),
      .expired     (tmr_expired),
      .load        (tmr_load),
      .load_val    (tmr_val),
      .prim_en     (prim_rail_en),
      .rail5_en    (rail5_en),
      .susp_ack    (susp_ack),
      .dsleep_pg   (dsleep_pgood),
      .resume_n    (resume_rst_n),
      .handover_en (handover_en),
      .chip_pg     (chip_pgood),
      .sys_pg      (sys_pgood),
      .status      (seq_status)
   );
endmodule

// File: tb/rail_seq_tb.sv
module rail_seq_tb;
   localparam longint unsigned HZ = 100_000;

   // expected waits, ceil(HZ * ns / 1e9) with a floor of one (R6)
   function automatic int cyc(longint unsigned ns);
      longint unsigned p;
      p = HZ * ns;
      if (p % 64'd1_000_000_000 != 0) p = p / 64'd1_000_000_000 + 1;
      else p = p / 64'd1_000_000_000;
      return (p == 0) ? 1 : int'(p);
   endfunction

   localparam int E_RTC  = 900;
   localparam int E_PRIM = 20;
   localparam int E_RAIL = 1000;
   localparam int E_RSM  = 9500;
   localparam int P0     = E_RTC + 1;
   localparam int NV     = 9;

   // bits: prim rail5 ack dsleep resume handover chip sys | status[1:0]
   localparam int POS [NV] = '{E_RTC-1, E_RTC, P0, P0+E_PRIM-1, P0+E_PRIM,
                               P0+E_PRIM+E_RAIL-1, P0+E_PRIM+E_RAIL,
                               P0+E_PRIM+E_RAIL+E_RSM-1, P0+E_PRIM+E_RAIL+E_RSM};
   localparam logic [9:0] EXP [NV] = '{10'b00000000_00, 10'b00000000_01,
                                       10'b10000000_11, 10'b10000000_11,
                                       10'b11100000_11, 10'b11100000_11,
                                       10'b11111000_11, 10'b11111000_11,
                                       10'b11111100_10};
   string tags [NV] = '{"R2", "R2", "R3", "R3", "R3", "R4", "R4", "R5", "R5"};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic suspend_warn_n = 1'b0;
   logic sleep_s3_n = 1'b1;
   logic all_pgood = 1'b0;
   logic prim_rail_en, rail5_en, susp_ack, dsleep_pgood, resume_rst_n;
   logic handover_en, chip_pgood, sys_pgood;
   logic [1:0] seq_status;
   int n_cmp = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   rail_seq #(.CLK_HZ(HZ), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .suspend_warn_n(suspend_warn_n),
      .sleep_s3_n(sleep_s3_n), .all_pgood(all_pgood),
      .prim_rail_en(prim_rail_en), .rail5_en(rail5_en), .susp_ack(susp_ack),
      .dsleep_pgood(dsleep_pgood), .resume_rst_n(resume_rst_n),
      .handover_en(handover_en), .chip_pgood(chip_pgood),
      .sys_pgood(sys_pgood), .seq_status(seq_status)
   );

   function automatic logic [9:0] obs();
      return {prim_rail_en, rail5_en, susp_ack, dsleep_pgood, resume_rst_n,
              handover_en, chip_pgood, sys_pgood, seq_status};
   endfunction

   task automatic check(string tag, logic [9:0] exp);
      logic [9:0] got;
      got = obs();
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s at %0t: got %b expected %b", tag, $time, got, exp);
      end
   endtask

   task automatic step(int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (200_000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      int cur;
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1", 10'b00000000_00);
      // R6: bench-side wait derivation matches the table constants
      n_cmp++;
      if (cyc(9_000_000) != E_RTC || cyc(200_000) != E_PRIM ||
          cyc(10_000_000) != E_RAIL || cyc(95_000_000) != E_RSM || cyc(400) != 1) begin
         n_bad++;
         $display("FAIL R6 wait table: got %0d expected 1", cyc(400));
      end
      rst_n = 1'b1;
      cur = 0;
      for (int i = 0; i < NV; i++) begin
         step(POS[i] - cur);
         cur = POS[i];
         check(tags[i], EXP[i]);
      end

      // R11: power-good pass-through in S5
      all_pgood = 1'b1;
      step(1); check("R11", 10'b11111110_10);
      step(1); check("R11", 10'b11111111_10);
      all_pgood = 1'b0;
      step(1); check("R11", 10'b11111100_10);
      all_pgood = 1'b1;
      step(2); check("R11", 10'b11111111_10);

      // R7, R8, R6: request removed -> power-down
      suspend_warn_n = 1'b1;
      step(2); check("R7", 10'b11111111_10);
      step(1); check("R7", 10'b10110000_11);
      step(1); check("R8 R6", 10'b00100000_11);
      step(1); check("R8", 10'b00100000_01);

      // R9: idle without request, then power-up on request
      step(50); check("R9", 10'b00100000_01);
      sleep_s3_n = 1'b0;
      step(2); check("R9", 10'b00100000_01);
      step(1); check("R9", 10'b10100000_11);

      // R10: request dropped mid-sequence; sequence still completes
      step(5);
      sleep_s3_n = 1'b1;
      step(E_PRIM - 5); check("R10", 10'b11100000_11);
      step(E_RAIL);     check("R10", 10'b11111000_11);
      step(E_RSM);      check("R10", 10'b11111100_10);
      step(1);          check("R10 R7", 10'b10110000_11);
      step(1);          check("R8", 10'b00100000_11);

      // R1: reset mid-run
      rst_n = 1'b0;
      #1;
      check("R1", 10'b00000000_00);
      step(2);
      check("R1", 10'b00000000_00);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule